// File: doc/BRIEF.md
# Twin-Array Product-Term Logic Cell

This block is a small configurable logic cell with 24 single-bit inputs and eight outputs. One shared AND plane forms product terms from true or complemented inputs. Two independent OR/XOR arrays, each serving four outputs, turn those terms into output functions. Each output picks one of three paths: a fast OR of four private terms, an XOR of one private term with a polarity term, or a wide OR over any of its array's twenty terms XORed with the polarity term. Each output is then shown either combinatorially or through a register.

Three extra product terms act as a block-local clock, a block-local register clear and an output-enable that leaves the cell for the I/O cells. The register clock is chosen from three global clocks or the local clock term. Configuration (term literals, per-output path, allocation and register choice, clock source and local clear enable) is written one word at a time through a parallel write port. The configuration storage is not cleared by reset, so it must be written after power-up.

Top module: `ptlb_core`

## Requirements
- R1: Term r (0 to 42) is configured by the word written at address r: bit j of [23:0] selects input j true and bit j of [47:24] selects input j complemented. The term is the AND of all selected literals, and a term with no literal selected is 0.
- R2: Outputs 0 to 3 use array terms 0 to 19 and outputs 4 to 7 use terms 20 to 39. Within an array with base b, output k (0 to 3) owns cluster terms b+4k to b+4k+3 and polarity term b+16+k.
- R3: The word at address 43+i configures output i as follows. Bits [19:0] are the allocation mask over its array's 20 terms, bits [21:20] are the path (0 four-term OR, 1 single-term XOR, 2 wide XOR, 3 off) and bit 22 selects the register. Path 0 gives the OR of the four cluster terms and path 3 gives 0.
- R4: Path 1 gives the first cluster term XOR the polarity term.
- R5: Path 2 gives the OR of the array terms whose allocation bit is set, XOR the polarity term.
- R6: With bit 22 clear, an output follows its path result with no clock. With it set, the output shows the value captured at the rising edge of the selected register clock and holds between edges.
- R7: The word at address 51 selects the register clock in bits [1:0]: values 0, 1 and 2 pick gclk[0], gclk[1] and gclk[2], and 3 picks the rising edge of term 40. Edges of the other clocks do not change registered outputs.
- R8: rst_n low clears all registered outputs to 0 at once, without a clock, and leaves combinatorial outputs unchanged.
- R9: When bit 2 of the word at address 51 is set, term 41 high clears the registered outputs while it stays high. When that bit is clear, term 41 has no effect.
- R10: pt_oe equals term 42.
- R11: A configuration word is stored at a rising edge of cfg_clk only when cfg_en is high. Otherwise the port is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low asynchronous clear of the output registers |
| gclk | input | 3 | Global register clocks |
| in_vec | input | 24 | Logic inputs to the AND plane |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_data | input | 48 | Configuration word |
| y | output | 8 | Logic outputs |
| pt_oe | output | 1 | Product-term output enable for the I/O cells |

## Verification
A corrupted configuration bit shows on y within the same cycle as a wrong function of in_vec. The vector walk drives inputs that make each literal, each path and each array decisive, so such a fault surfaces there. A register holding a wrong value is visible on its output at once and stays wrong until the next edge of the selected clock. A clock mux that picks the wrong source shows as a registered output that moves one or more edges early or late, which the bench exposes by pulsing each clock alone. A clear path stuck on or off shows as a registered output that reads 0 when it should hold data, or that keeps data while its clear is active.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    typedef enum logic [1:0] {
        PATH_BYP4  = 2'd0,
        PATH_XOR1  = 2'd1,
        PATH_XOR20 = 2'd2,
        PATH_OFF   = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        CLK_G0 = 2'd0,
        CLK_G1 = 2'd1,
        CLK_G2 = 2'd2,
        CLK_PT = 2'd3
    } clk_src_e;

    localparam int CTRL_TERMS = 3;

endpackage

// File: rtl/ptlb_cfg_store.sv
module ptlb_cfg_store #(
    parameter int N_IN    = 24,
    parameter int N_PT    = 43,
    parameter int N_OUT   = 8,
    parameter int ALLOC_W = 20,
    parameter int AW      = 6,
    parameter int DW      = 48
) (
    input  logic                              clk,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     wr_addr,
    input  logic [DW-1:0]                     wr_data,
    output logic [N_PT-1:0][N_IN-1:0]         lit_true,
    output logic [N_PT-1:0][N_IN-1:0]         lit_comp,
    output logic [N_OUT-1:0][ALLOC_W-1:0]     alloc,
    output logic [N_OUT-1:0][1:0]             path,
    output logic [N_OUT-1:0]                  reg_en,
    output logic [1:0]                        clk_src,
    output logic                              ptrst_en
);

    localparam int OUT_BASE = N_PT;
    localparam int GLB_ADDR = N_PT + N_OUT;
    localparam int PATH_LSB = ALLOC_W;
    localparam int REG_BIT  = ALLOC_W + 2;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int r = 0; r < N_PT; r++) begin
                if (wr_addr == AW'(r)) begin
                    lit_true[r] <= wr_data[N_IN-1:0];
                    lit_comp[r] <= wr_data[2*N_IN-1:N_IN];
                end
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (wr_addr == AW'(OUT_BASE + o)) begin
                    alloc[o]  <= wr_data[ALLOC_W-1:0];
                    path[o]   <= wr_data[PATH_LSB +: 2];
                    reg_en[o] <= wr_data[REG_BIT];
                end
            end
            if (wr_addr == AW'(GLB_ADDR)) begin
                clk_src  <= wr_data[1:0];
                ptrst_en <= wr_data[2];
            end
        end
    end

endmodule

// File: rtl/ptlb_and_plane.sv
module ptlb_and_plane #(
    parameter int N_IN = 24,
    parameter int N_PT = 43
) (
    input  logic [N_IN-1:0]           lit_in,
    input  logic [N_PT-1:0][N_IN-1:0] sel_true,
    input  logic [N_PT-1:0][N_IN-1:0] sel_comp,
    output logic [N_PT-1:0]           pt
);

    for (genvar r = 0; r < N_PT; r++) begin : g_term
        logic any_sel;
        logic all_ok;
        assign any_sel = |(sel_true[r] | sel_comp[r]);
        assign all_ok  = &((~sel_true[r] | lit_in) & (~sel_comp[r] | ~lit_in));
        // an unprogrammed term is shut down to 0
        assign pt[r]   = any_sel & all_ok;
    end

endmodule

// File: rtl/ptlb_orxor_array.sv
module ptlb_orxor_array
    import ptlb_pkg::*;
#(
    parameter int OUT_PER_ARR = 4,
    parameter int BYP_PT      = 4,
    parameter int ARR_TERMS   = 20
) (
    input  logic [ARR_TERMS-1:0]                  terms,
    input  logic [OUT_PER_ARR-1:0][ARR_TERMS-1:0] alloc,
    input  logic [OUT_PER_ARR-1:0][1:0]           path,
    output logic [OUT_PER_ARR-1:0]                res
);

    localparam int XOR_BASE = OUT_PER_ARR * BYP_PT;

    for (genvar k = 0; k < OUT_PER_ARR; k++) begin : g_out
        logic byp_or;
        logic wide_or;
        logic pol;
        logic sum;

        assign byp_or  = |terms[k*BYP_PT +: BYP_PT];
        assign wide_or = |(terms & alloc[k]);
        assign pol     = terms[XOR_BASE + k];

        always_comb begin
            unique case (path_e'(path[k]))
                PATH_BYP4:  sum = byp_or;
                PATH_XOR1:  sum = terms[k*BYP_PT] ^ pol;
                PATH_XOR20: sum = wide_or ^ pol;
                PATH_OFF:   sum = 1'b0;
            endcase
        end

        assign res[k] = sum;
    end

endmodule

// File: rtl/ptlb_out_regs.sv
module ptlb_out_regs
    import ptlb_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int N_GCLK = 3
) (
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              rst_n,
    input  logic              pt_rst,
    input  logic              ptrst_en,
    input  logic [1:0]        clk_src,
    input  logic [N_OUT-1:0]  d,
    input  logic [N_OUT-1:0]  reg_en,
    output logic [N_OUT-1:0]  y,
    output logic [N_OUT-1:0]  q,
    output logic              clr
);

    logic reg_clk;

    always_comb begin
        reg_clk = pt_clk;
        for (int g = 0; g < N_GCLK; g++) begin
            if (clk_src == 2'(g)) begin
                reg_clk = gclk[g];
            end
        end
    end

    assign clr = ~rst_n | (ptrst_en & pt_rst);

    always_ff @(posedge reg_clk or posedge clr) begin
        if (clr) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign y = (reg_en & q) | (~reg_en & d);

endmodule

// File: rtl/ptlb_core.sv
module ptlb_core
    import ptlb_pkg::*;
#(
    parameter int N_IN   = 24,
    parameter int N_OUT  = 8,
    parameter int N_ARR  = 2,
    parameter int BYP_PT = 4,
    parameter int N_GCLK = 3,
    localparam int OUT_PER_ARR = N_OUT / N_ARR,
    localparam int ARR_TERMS   = OUT_PER_ARR * (BYP_PT + 1),
    localparam int N_LOGIC_PT  = N_ARR * ARR_TERMS,
    localparam int N_PT        = N_LOGIC_PT + CTRL_TERMS,
    localparam int AW          = $clog2(N_PT + N_OUT + 1),
    localparam int DW          = 2 * N_IN
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_IN-1:0]   in_vec,
    input  logic              cfg_en,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_data,
    output logic [N_OUT-1:0]  y,
    output logic              pt_oe
);

    localparam int PT_CLK_IDX = N_LOGIC_PT;
    localparam int PT_RST_IDX = N_LOGIC_PT + 1;
    localparam int PT_OE_IDX  = N_LOGIC_PT + 2;
    localparam int CFG_IMG_W  = 2 * N_PT * N_IN + N_OUT * (ARR_TERMS + 3) + 3;

    logic [N_PT-1:0][N_IN-1:0]       lit_true;
    logic [N_PT-1:0][N_IN-1:0]       lit_comp;
    logic [N_OUT-1:0][ARR_TERMS-1:0] alloc;
    logic [N_OUT-1:0][1:0]           path_cfg;
    logic [N_OUT-1:0]                reg_en;
    logic [1:0]                      clk_src;
    logic                            ptrst_en;
    logic [N_PT-1:0]                 pt;
    logic [N_OUT-1:0]                comb_y;
    logic [N_OUT-1:0]                reg_q;
    logic                            reg_clr;
    logic [CFG_IMG_W-1:0]            cfg_image;

    ptlb_cfg_store #(
        .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT),
        .ALLOC_W(ARR_TERMS), .AW(AW), .DW(DW)
    ) u_cfg (
        .clk      (cfg_clk),
        .wr_en    (cfg_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .lit_true (lit_true),
        .lit_comp (lit_comp),
        .alloc    (alloc),
        .path     (path_cfg),
        .reg_en   (reg_en),
        .clk_src  (clk_src),
        .ptrst_en (ptrst_en)
    );

    ptlb_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_plane (
        .lit_in   (in_vec),
        .sel_true (lit_true),
        .sel_comp (lit_comp),
        .pt       (pt)
    );

    for (genvar a = 0; a < N_ARR; a++) begin : g_arr
        ptlb_orxor_array #(
            .OUT_PER_ARR(OUT_PER_ARR), .BYP_PT(BYP_PT), .ARR_TERMS(ARR_TERMS)
        ) u_arr (
            .terms (pt[a*ARR_TERMS +: ARR_TERMS]),
            .alloc (alloc[a*OUT_PER_ARR +: OUT_PER_ARR]),
            .path  (path_cfg[a*OUT_PER_ARR +: OUT_PER_ARR]),
            .res   (comb_y[a*OUT_PER_ARR +: OUT_PER_ARR])
        );
    end

    ptlb_out_regs #(.N_OUT(N_OUT), .N_GCLK(N_GCLK)) u_regs (
        .gclk     (gclk),
        .pt_clk   (pt[PT_CLK_IDX]),
        .rst_n    (rst_n),
        .pt_rst   (pt[PT_RST_IDX]),
        .ptrst_en (ptrst_en),
        .clk_src  (clk_src),
        .d        (comb_y),
        .reg_en   (reg_en),
        .y        (y),
        .q        (reg_q),
        .clr      (reg_clr)
    );

    assign pt_oe     = pt[PT_OE_IDX];
    assign cfg_image = {lit_true, lit_comp, alloc, path_cfg, reg_en, clk_src, ptrst_en};

endmodule

// File: rtl/ptlb_core_chk.sv
module ptlb_core_chk #(
    parameter int N_OUT = 8,
    parameter int IMG_W = 8
) (
    input logic             clk,
    input logic             cfg_clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [IMG_W-1:0] cfg_image,
    input logic [1:0]       clk_src,
    input logic             ptrst_en,
    input logic             pt_rst,
    input logic             reg_clr,
    input logic [N_OUT-1:0] reg_q,
    input logic [N_OUT-1:0] reg_d
);

    AST_CFG_FROZEN: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_image)); // R11

    AST_RST_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (reg_q == '0)); // R8

    AST_PTRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ptrst_en && pt_rst) |-> (reg_q == '0)); // R9

    AST_CAPTURE_G0: assert property (@(posedge clk) disable iff (reg_clr)
        (clk_src == 2'd0 && !reg_clr) |=> (reg_q == $past(reg_d))); // R6

endmodule

bind ptlb_core ptlb_core_chk #(.N_OUT(N_OUT), .IMG_W(CFG_IMG_W)) u_chk (
    .clk       (gclk[0]),
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_image (cfg_image),
    .clk_src   (clk_src),
    .ptrst_en  (ptrst_en),
    .pt_rst    (pt[PT_RST_IDX]),
    .reg_clr   (reg_clr),
    .reg_q     (reg_q),
    .reg_d     (comb_y)
);

// File: tb/test_ptlb_core.sv
module test_ptlb_core;

    localparam int N_IN  = 24;
    localparam int N_OUT = 8;
    localparam int AW    = 6;
    localparam int DW    = 48;
    localparam int GLB   = 51;
    localparam logic [23:0] X22 = 24'h400000;
    localparam logic [23:0] X23 = 24'h800000;
    localparam logic [23:0] V4X = 24'h000704;
    localparam logic [23:0] V5X = 24'h005804;

    // {expected pt_oe, stimulus, expected y}
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 24'h000000, 8'h05},
        {1'b0, 24'h000007, 8'h01},
        {1'b0, 24'h000014, 8'h02},
        {1'b0, 24'h000070, 8'h05},
        {1'b0, 24'h000704, 8'h54},
        {1'b0, 24'h005804, 8'hA4},
        {1'b1, 24'h106304, 8'h04},
        {1'b0, 24'h301057, 8'h47}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              g1, g2;
    logic              cfg_en;
    logic [AW-1:0]     cfg_addr;
    logic [DW-1:0]     cfg_data;
    logic [N_IN-1:0]   x;
    logic [N_OUT-1:0]  y;
    logic              oe;
    int                total = 0;
    int                bad = 0;

    always #10 clk = ~clk;

    ptlb_core i_ptlb_core (
        .cfg_clk  (clk),
        .rst_n    (rst_n),
        .gclk     ({g2, g1, clk}),
        .in_vec   (x),
        .cfg_en   (cfg_en),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .y        (y),
        .pt_oe    (oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_en   = 1'b1;
        cfg_addr = AW'(a);
        cfg_data = d;
        @(negedge clk);
        cfg_en   = 1'b0;
    endtask

    function automatic logic [DW-1:0] term(input logic [23:0] t, input logic [23:0] c);
        return {c, t};
    endfunction

    function automatic logic [DW-1:0] ocfg(input logic r, input logic [1:0] p, input logic [19:0] m);
        return DW'({r, p, m});
    endfunction

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b1; g1 = 1'b0; g2 = 1'b0; cfg_en = 1'b0;
        cfg_addr = '0; cfg_data = '0; x = '0;
        #1 rst_n = 1'b0;

        for (int a = 0; a <= GLB; a++) wr(a, '0);
        wr(0,  term(24'h000003, 24'h0));
        wr(1,  term(24'h0, 24'h000004));
        wr(3,  term(24'h000008, 24'h000008));
        wr(4,  term(24'h000010, 24'h0));
        wr(12, term(24'h000080, 24'h0));
        wr(17, term(24'h000020, 24'h0));
        wr(18, term(24'h0, 24'h000040));
        wr(20, term(24'h000700, 24'h0));
        wr(24, term(24'h000800, 24'h0));
        wr(32, term(24'h004000, 24'h002000));
        wr(38, term(24'h001000, 24'h0));
        wr(40, term(X23, 24'h0));
        wr(41, term(X22, 24'h0));
        wr(42, term(24'h100000, 24'h200000));
        wr(43, ocfg(1'b0, 2'd0, 20'h0));
        wr(44, ocfg(1'b0, 2'd1, 20'h0));
        wr(45, ocfg(1'b0, 2'd2, 20'h00011));
        wr(46, ocfg(1'b0, 2'd3, 20'h0));
        wr(47, ocfg(1'b0, 2'd0, 20'h0));
        wr(48, ocfg(1'b0, 2'd1, 20'h0));
        wr(49, ocfg(1'b0, 2'd2, 20'h00011));
        wr(50, ocfg(1'b1, 2'd0, 20'h0));

        // reset state: registered output cleared, pt_oe low
        #2;
        chk("R8 reset state y", 32'(y), 32'h05);
        chk("R10 reset state pt_oe", 32'(oe), 32'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            x = VEC[v][31:8];
            @(posedge clk);
            #2;
            chk($sformatf("R1 R2 R3 R4 R5 vector %0d", v), 32'(y[6:0]), 32'(VEC[v][6:0]));
            chk($sformatf("R6 registered vector %0d", v), 32'(y[7]), 32'(VEC[v][7]));
            chk($sformatf("R10 pt_oe vector %0d", v), 32'(oe), 32'(VEC[v][32]));
        end

        // R6: registered output waits for the edge, combinatorial does not
        @(negedge clk);
        x = V5X;
        #2;
        chk("R6 registered before edge", 32'(y[7]), 32'h0);
        chk("R6 combinatorial immediate", 32'(y[5]), 32'h1);
        @(posedge clk);
        #2;
        chk("R6 registered after edge", 32'(y[7]), 32'h1);

        // R8: asynchronous global clear
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R8 clear without clock", 32'(y[7]), 32'h0);
        chk("R8 combinatorial unaffected", 32'(y[5]), 32'h1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R8 recapture after release", 32'(y[7]), 32'h1);

        // R9: local clear disabled, then enabled
        @(negedge clk);
        x = V5X | X22;
        #2;
        chk("R9 disabled no clear", 32'(y[7]), 32'h1);
        @(posedge clk);
        #2;
        chk("R9 disabled no clear after edge", 32'(y[7]), 32'h1);
        @(negedge clk) x = V5X;
        wr(GLB, 48'h4);
        @(negedge clk);
        x = V5X | X22;
        #2;
        chk("R9 enabled clears", 32'(y[7]), 32'h0);
        @(posedge clk);
        #2;
        chk("R9 held clear over edge", 32'(y[7]), 32'h0);
        @(negedge clk) x = V5X;
        @(posedge clk);
        #2;
        chk("R9 capture after release", 32'(y[7]), 32'h1);

        // R7: clock source selection
        wr(GLB, 48'h1);
        @(negedge clk) x = V4X;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R7 gclk0 ignored under gclk1", 32'(y[7]), 32'h1);
        @(negedge clk);
        g1 = 1'b1;
        #2;
        chk("R7 gclk1 captures", 32'(y[7]), 32'h0);
        g1 = 1'b0;
        wr(GLB, 48'h2);
        @(negedge clk) x = V5X;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R7 gclk0 ignored under gclk2", 32'(y[7]), 32'h0);
        @(negedge clk);
        g2 = 1'b1;
        #2;
        chk("R7 gclk2 captures", 32'(y[7]), 32'h1);
        g2 = 1'b0;
        wr(GLB, 48'h3);
        @(negedge clk) x = V4X;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R7 gclk0 ignored under term clock", 32'(y[7]), 32'h1);
        @(negedge clk);
        x = V4X | X23;
        #2;
        chk("R7 term clock captures", 32'(y[7]), 32'h0);
        x = V4X;
        wr(GLB, 48'h0);

        // R11: port ignored while cfg_en is low
        @(negedge clk);
        x = 24'h000000;
        cfg_addr = AW'(43);
        cfg_data = ocfg(1'b0, 2'd3, 20'h0);
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R11 write ignored", 32'(y[0]), 32'h1);
        wr(43, ocfg(1'b0, 2'd3, 20'h0));
        #2;
        chk("R11 write taken", 32'(y[0]), 32'h0);
        chk("R3 off path and others", 32'(y[6:0]), 32'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule